// File: doc/BRIEF.md
# Serial Flash Command Framing Validator

This block is the slave-side command front end of a serial NOR flash on a single-line SPI link in mode 0. The serial clock, chip select and data input are sampled by the chip's system clock. Each chip-select window is split into bytes: one opcode byte first, then address bytes and data bytes, all most significant bit first. Bits are taken on rising edges of the serial clock.

Write-type and erase-type commands are only judged when chip select rises. The window must end on a whole byte. The number of bytes after the opcode must fit the command. The write-enable latch must allow the command, and the array must not be busy. When every check holds, the block issues a one-cycle execute pulse. The pulse carries the decoded command, the 24-bit address and the count of data bytes. A command that fails any check is dropped without trace, and the latch keeps its value.

Read-type commands do not wait for chip select. The block pulses a start strobe to the data-out path as soon as the opcode is complete for a status read. For a data read or fast read it pulses once the three address bytes are complete. Whatever follows in that window is left to the output path.

Top module: `spi_cmd_front`

## Requirements
- R1: Opcode and address bits are taken most significant bit first on serial clock rising edges; the address reported is the three bytes after the opcode, first byte in bits 23:16.
- R2: Opcode 06h with chip select rising on a byte boundary sets the write-enable latch and pulses execute with command code 1.
- R3: Opcodes 06h, 04h, 02h, 20h, 52h, D8h, C7h, 01h and B9h are dropped when the bit count of the window is not a multiple of eight. Opcode B9h, when framed correctly, pulses execute with code 9 and no latch condition.
- R4: Opcode 02h (code 3) needs at least four bytes after the opcode; its reported count is the number of bytes after the address; three or fewer bytes drop it.
- R5: Opcodes 20h, 52h and D8h (codes 4, 5, 6) execute only with exactly three bytes after the opcode, and carry that address.
- R6: Codes 3 to 8 (program, erases, chip erase C7h code 7, write status) execute only with the write-enable latch set, and clear it when they execute. Opcode 04h (code 2) clears the latch.
- R7: While the busy input is high, every command except status read (05h) is ignored and the latch is unchanged; status read still starts.
- R8: Opcode 03h (code 10) and 0Bh (code 11) pulse the read start strobe once, with the address, when the third address byte completes; a window that ends earlier starts nothing.
- R9: An opcode outside the listed set causes neither execute nor read start for the rest of its window.
- R10: After reset the latch is clear and both strobes are low.
- R11: Each execute pulse and each read start pulse lasts exactly one system clock cycle.
- R12: Opcode 01h (code 8) needs exactly one byte after the opcode and reports a count of 1.
- R13: Chip select high clears the bit and byte framing, so a partial window has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data input |
| busy_i | input | 1 | Array busy with an internal operation |
| exec_valid_o | output | 1 | One-cycle execute pulse |
| exec_cmd_o | output | 4 | Decoded command code for execute |
| exec_addr_o | output | 24 | Address for program and erase, else zero |
| exec_count_o | output | CNT_W | Data byte count (saturating) |
| wel_o | output | 1 | Write-enable latch |
| rd_start_o | output | 1 | One-cycle read start strobe |
| rd_cmd_o | output | 4 | Decoded read command code |
| rd_addr_o | output | 24 | Read start address |

## Verification
The assertions take for granted that the serial clock is slow against the system clock. Every level must last longer than the synchronizer depth plus one cycle. Chip select must not move in the same system cycle as a serial clock edge. The busy input is taken to be synchronous to the system clock and steady around a chip-select rise. The stimulus holds each serial clock level for four system cycles and changes data only while the serial clock is low. It leaves four cycles between the last clock edge and chip select, and changes busy only while chip select is high.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   typedef enum logic [3:0] {
      CMD_NONE  = 4'd0,
      CMD_WREN  = 4'd1,
      CMD_WRDI  = 4'd2,
      CMD_PROG  = 4'd3,
      CMD_SECT  = 4'd4,
      CMD_HALF  = 4'd5,
      CMD_BLOCK = 4'd6,
      CMD_CHIP  = 4'd7,
      CMD_WSTAT = 4'd8,
      CMD_SLEEP = 4'd9,
      CMD_READ  = 4'd10,
      CMD_FREAD = 4'd11,
      CMD_RSTAT = 4'd12
   } cmd_e;

   function automatic cmd_e op_decode(input logic [7:0] op);
      case (op)
         8'h06:   return CMD_WREN;
         8'h04:   return CMD_WRDI;
         8'h02:   return CMD_PROG;
         8'h20:   return CMD_SECT;
         8'h52:   return CMD_HALF;
         8'hD8:   return CMD_BLOCK;
         8'hC7:   return CMD_CHIP;
         8'h01:   return CMD_WSTAT;
         8'hB9:   return CMD_SLEEP;
         8'h03:   return CMD_READ;
         8'h0B:   return CMD_FREAD;
         8'h05:   return CMD_RSTAT;
         default: return CMD_NONE;
      endcase
   endfunction

   function automatic logic needs_wel(input cmd_e c);
      return (c == CMD_PROG) || (c == CMD_SECT) || (c == CMD_HALF) ||
             (c == CMD_BLOCK) || (c == CMD_CHIP) || (c == CMD_WSTAT);
   endfunction

   function automatic logic has_addr(input cmd_e c);
      return (c == CMD_PROG) || (c == CMD_SECT) || (c == CMD_HALF) ||
             (c == CMD_BLOCK);
   endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic cs_s,
   output logic mosi_s,
   output logic sck_rise,
   output logic cs_rise
);
   logic [2:0] raw, cur;
   logic       sck_q, cs_q;

   assign raw = {sck, cs_n, mosi};

   if (STAGES == 0) begin : g_direct
      assign cur = raw;
   end else begin : g_sync
      logic [2:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b010;
         end else begin
            pipe[0] <= raw;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign cur = pipe[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= cur[2];
         cs_q  <= cur[1];
      end
   end

   assign cs_s     = cur[1];
   assign mosi_s   = cur[0];
   assign sck_rise = cur[2] & ~sck_q;
   assign cs_rise  = cur[1] & ~cs_q;
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift #(
   parameter int BC_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_s,
   input  logic            sck_rise,
   input  logic            mosi_s,
   output logic [7:0]      opcode,
   output logic [BC_W-1:0] nbytes,
   output logic [23:0]     addr,
   output logic            aligned,
   output logic            byte_done
);
   logic [2:0] bitcnt;
   logic [7:0] sh;
   logic [7:0] nxt;

   assign nxt     = {sh[6:0], mosi_s};
   assign aligned = (bitcnt == 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt    <= '0;
         sh        <= '0;
         nbytes    <= '0;
         opcode    <= '0;
         addr      <= '0;
         byte_done <= 1'b0;
      end else if (cs_s) begin
         bitcnt    <= '0;
         sh        <= '0;
         nbytes    <= '0;
         opcode    <= '0;
         addr      <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sck_rise) begin
            bitcnt <= bitcnt + 3'd1;
            sh     <= nxt;
            if (bitcnt == 3'd7) begin
               byte_done <= 1'b1;
               if (nbytes != '1) nbytes <= nbytes + BC_W'(1);
               if (nbytes == '0) opcode <= nxt;
               else if (nbytes <= BC_W'(3)) addr <= {addr[15:0], nxt};
            end
         end
      end
   end
endmodule

// File: rtl/spi_frame_judge.sv
module spi_frame_judge
   import spi_cmd_pkg::*;
#(
   parameter int BC_W  = 10,
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_rise,
   input  logic             byte_done,
   input  logic [7:0]       opcode,
   input  logic [BC_W-1:0]  nbytes,
   input  logic [23:0]      addr,
   input  logic             aligned,
   input  logic             busy,
   output logic             exec_valid,
   output logic [3:0]       exec_cmd,
   output logic [23:0]      exec_addr,
   output logic [CNT_W-1:0] exec_count,
   output logic             wel,
   output logic             rd_start,
   output logic [3:0]       rd_cmd,
   output logic [23:0]      rd_addr
);
   cmd_e            cmd;
   logic [BC_W-1:0] after, pp_n;
   logic            shape_ok, go, rd_go;

   assign cmd   = (nbytes != '0) ? op_decode(opcode) : CMD_NONE;
   assign after = nbytes - BC_W'(1);
   assign pp_n  = after - BC_W'(3);

   always_comb begin
      case (cmd)
         CMD_WREN, CMD_WRDI, CMD_CHIP, CMD_SLEEP: shape_ok = 1'b1;
         CMD_PROG:                   shape_ok = (after >= BC_W'(4));
         CMD_SECT, CMD_HALF, CMD_BLOCK: shape_ok = (after == BC_W'(3));
         CMD_WSTAT:                  shape_ok = (after == BC_W'(1));
         default:                    shape_ok = 1'b0;
      endcase
   end

   assign go = cs_rise && aligned && shape_ok && !busy && (!needs_wel(cmd) || wel);

   assign rd_go = byte_done &&
                  (((cmd == CMD_RSTAT) && (nbytes == BC_W'(1))) ||
                   (((cmd == CMD_READ) || (cmd == CMD_FREAD)) &&
                    (nbytes == BC_W'(4)) && !busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exec_valid <= 1'b0;
         exec_cmd   <= '0;
         exec_addr  <= '0;
         exec_count <= '0;
         wel        <= 1'b0;
         rd_start   <= 1'b0;
         rd_cmd     <= '0;
         rd_addr    <= '0;
      end else begin
         exec_valid <= go;
         rd_start   <= rd_go;
         if (go) begin
            exec_cmd  <= cmd;
            exec_addr <= has_addr(cmd) ? addr : 24'd0;
            if (cmd == CMD_PROG)
               exec_count <= pp_n[BC_W-1] ? '1 : pp_n[CNT_W-1:0];
            else if (cmd == CMD_WSTAT)
               exec_count <= CNT_W'(1);
            else
               exec_count <= '0;
            if (cmd == CMD_WREN) wel <= 1'b1;
            else if ((cmd == CMD_WRDI) || needs_wel(cmd)) wel <= 1'b0;
         end
         if (rd_go) begin
            rd_cmd  <= cmd;
            rd_addr <= addr;
         end
      end
   end
endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front #(
   parameter int CNT_W       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_sck,
   input  logic             spi_cs_n,
   input  logic             spi_mosi,
   input  logic             busy_i,
   output logic             exec_valid_o,
   output logic [3:0]       exec_cmd_o,
   output logic [23:0]      exec_addr_o,
   output logic [CNT_W-1:0] exec_count_o,
   output logic             wel_o,
   output logic             rd_start_o,
   output logic [3:0]       rd_cmd_o,
   output logic [23:0]      rd_addr_o
);
   localparam int BC_W = CNT_W + 1;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic            cs_s, mosi_s, sck_rise, cs_rise;
   logic [7:0]      opcode;
   logic [BC_W-1:0] nbytes;
   logic [23:0]     addr;
   logic            aligned, byte_done;

   spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .cs_s(cs_s), .mosi_s(mosi_s), .sck_rise(sck_rise), .cs_rise(cs_rise)
   );

   spi_frame_shift #(.BC_W(BC_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_rise(sck_rise), .mosi_s(mosi_s),
      .opcode(opcode), .nbytes(nbytes), .addr(addr), .aligned(aligned),
      .byte_done(byte_done)
   );

   spi_frame_judge #(.BC_W(BC_W), .CNT_W(CNT_W)) u_judge (
      .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .byte_done(byte_done),
      .opcode(opcode), .nbytes(nbytes), .addr(addr), .aligned(aligned),
      .busy(busy_i), .exec_valid(exec_valid_o), .exec_cmd(exec_cmd_o),
      .exec_addr(exec_addr_o), .exec_count(exec_count_o), .wel(wel_o),
      .rd_start(rd_start_o), .rd_cmd(rd_cmd_o), .rd_addr(rd_addr_o)
   );
endmodule

// File: rtl/spi_cmd_front_chk.sv
module spi_cmd_front_chk
   import spi_cmd_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_i,
   input logic             exec_valid_o,
   input logic [3:0]       exec_cmd_o,
   input logic [CNT_W-1:0] exec_count_o,
   input logic             wel_o,
   input logic             rd_start_o,
   input logic [3:0]       rd_cmd_o
);
   AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid_o |=> !exec_valid_o); // R11

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start_o |=> !rd_start_o); // R11

   AST_WEL_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid_o && needs_wel(cmd_e'(exec_cmd_o))) |-> $past(wel_o)); // R6

   AST_WEL_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid_o && needs_wel(cmd_e'(exec_cmd_o))) |-> !wel_o); // R6

   AST_WEL_ONLY_ON_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_valid_o |-> $stable(wel_o)); // R3

   AST_WREN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid_o && (exec_cmd_o == CMD_WREN)) |-> wel_o); // R2

   AST_NOT_BUSY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid_o |-> !$past(busy_i)); // R7

   AST_NOT_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start_o && (rd_cmd_o != CMD_RSTAT)) |-> !$past(busy_i)); // R7

   AST_PROG_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid_o && (exec_cmd_o == CMD_PROG)) |-> (exec_count_o != '0)); // R4
endmodule

bind spi_cmd_front spi_cmd_front_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .exec_valid_o(exec_valid_o),
   .exec_cmd_o(exec_cmd_o), .exec_count_o(exec_count_o), .wel_o(wel_o),
   .rd_start_o(rd_start_o), .rd_cmd_o(rd_cmd_o)
);

// File: tb/sim_spi_cmd_front.sv
module sim_spi_cmd_front;
   localparam int CNT_W = 9;
   localparam int NV    = 28;

   typedef struct packed {
      logic [7:0]  op;
      logic [23:0] ad;
      logic [7:0]  nb;
      logic [2:0]  ext;
      logic        bz;
      logic        xe;
      logic [3:0]  xcmd;
      logic [8:0]  xcnt;
      logic        xwel;
      logic        xrd;
      logic [3:0]  xrcmd;
      logic [3:0]  req;
   } vec_t;

   function automatic vec_t mk(int op, int ad, int nb, int ext, int bz, int xe,
                               int xcmd, int xcnt, int xwel, int xrd, int xrcmd, int req);
      vec_t v;
      v.op = 8'(op); v.ad = 24'(ad); v.nb = 8'(nb); v.ext = 3'(ext); v.bz = 1'(bz);
      v.xe = 1'(xe); v.xcmd = 4'(xcmd); v.xcnt = 9'(xcnt); v.xwel = 1'(xwel);
      v.xrd = 1'(xrd); v.xrcmd = 4'(xrcmd); v.req = 4'(req);
      return v;
   endfunction

   // op, addr, bytes after op, extra bits, busy, exp exec, cmd, count, wel, exp rd, rd cmd, req
   localparam vec_t VEC [NV] = '{
      mk('h06, 0,        0, 0, 0, 1, 1, 0, 1, 0, 0,  2),  // R2 set latch
      mk('h20, 'h123456, 3, 0, 0, 1, 4, 0, 0, 0, 0,  5),  // R5 sector erase
      mk('h20, 'h123456, 3, 0, 0, 0, 0, 0, 0, 0, 0,  6),  // R6 no latch
      mk('h06, 0,        0, 0, 0, 1, 1, 0, 1, 0, 0,  2),
      mk('h20, 'h111111, 4, 0, 0, 0, 0, 0, 1, 0, 0,  5),  // R5 too long
      mk('h20, 'h111111, 2, 0, 0, 0, 0, 0, 1, 0, 0,  5),  // R5 too short
      mk('h02, 'h222222, 3, 0, 0, 0, 0, 0, 1, 0, 0,  4),  // R4 no data byte
      mk('h02, 'h222222, 5, 3, 0, 0, 0, 0, 1, 0, 0,  3),  // R3 partial byte
      mk('h02, 'h00ABCD, 6, 0, 0, 1, 3, 3, 0, 0, 0,  4),  // R4 three data bytes
      mk('h06, 0,        0, 0, 1, 0, 0, 0, 0, 0, 0,  7),  // R7 busy
      mk('h06, 0,        0, 0, 0, 1, 1, 0, 1, 0, 0,  2),
      mk('h01, 0,        2, 0, 0, 0, 0, 0, 1, 0, 0, 12),  // R12 two bytes
      mk('h01, 0,        1, 0, 0, 1, 8, 1, 0, 0, 0, 12),  // R12 one byte
      mk('h06, 0,        0, 0, 0, 1, 1, 0, 1, 0, 0,  2),
      mk('h04, 0,        0, 0, 0, 1, 2, 0, 0, 0, 0,  6),  // R6 write disable
      mk('h06, 0,        0, 0, 0, 1, 1, 0, 1, 0, 0,  2),
      mk('hC7, 0,        0, 0, 1, 0, 0, 0, 1, 0, 0,  7),  // R7 chip erase busy
      mk('h52, 'h0F0F0F, 3, 0, 0, 1, 5, 0, 0, 0, 0,  5),  // R5 half block
      mk('h5A, 0,        4, 0, 0, 0, 0, 0, 0, 0, 0,  9),  // R9 unknown
      mk('h03, 'hFEDCBA, 3, 5, 0, 0, 0, 0, 0, 1, 10, 8),  // R8 read, early stop
      mk('h03, 'hFEDCBA, 2, 7, 0, 0, 0, 0, 0, 0, 0,  8),  // R8 address short
      mk('h0B, 'h010203, 4, 0, 0, 0, 0, 0, 0, 1, 11, 8),  // R8 fast read
      mk('h05, 0,        0, 0, 1, 0, 0, 0, 0, 1, 12, 7),  // R7 status read busy
      mk('h03, 'h0000FF, 3, 0, 1, 0, 0, 0, 0, 0, 0,  7),  // R7 read busy
      mk('hB9, 0,        0, 0, 0, 1, 9, 0, 0, 0, 0,  3),  // R3 sleep
      mk('h06, 0,        0, 0, 0, 1, 1, 0, 1, 0, 0,  2),
      mk('hD8, 'h800000, 3, 0, 0, 1, 6, 0, 0, 0, 0,  5),  // R5 block erase
      mk('h06, 0,        0, 4, 0, 0, 0, 0, 0, 0, 0,  3)   // R3 partial byte
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, busy_i = 1'b0;
   logic             exec_valid_o, wel_o, rd_start_o;
   logic [3:0]       exec_cmd_o, rd_cmd_o;
   logic [23:0]      exec_addr_o, rd_addr_o;
   logic [CNT_W-1:0] exec_count_o;

   int n_chk = 0, n_fail = 0;
   int exec_seen = 0, rd_seen = 0, long_pulse = 0;
   logic [3:0]       last_cmd = '0, last_rcmd = '0;
   logic [23:0]      last_addr = '0, last_raddr = '0;
   logic [CNT_W-1:0] last_cnt = '0;
   logic             prev_e = 1'b0, prev_r = 1'b0;

   always #10 clk = ~clk;

   spi_cmd_front #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .busy_i(busy_i), .exec_valid_o(exec_valid_o),
      .exec_cmd_o(exec_cmd_o), .exec_addr_o(exec_addr_o), .exec_count_o(exec_count_o),
      .wel_o(wel_o), .rd_start_o(rd_start_o), .rd_cmd_o(rd_cmd_o), .rd_addr_o(rd_addr_o)
   );

   always @(negedge clk) begin
      if (exec_valid_o) begin
         exec_seen <= exec_seen + 1;
         last_cmd  <= exec_cmd_o;
         last_addr <= exec_addr_o;
         last_cnt  <= exec_count_o;
      end
      if (rd_start_o) begin
         rd_seen    <= rd_seen + 1;
         last_rcmd  <= rd_cmd_o;
         last_raddr <= rd_addr_o;
      end
      if ((exec_valid_o && prev_e) || (rd_start_o && prev_r)) long_pulse <= long_pulse + 1;
      prev_e <= exec_valid_o;
      prev_r <= rd_start_o;
   end

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      spi_mosi = b;
      wait_clk(4);
      spi_sck = 1'b1;
      wait_clk(4);
      spi_sck = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
   endtask

   task automatic frame(input logic [7:0] op, input logic [23:0] ad, input int nb,
                        input int ext, input logic bz);
      busy_i = bz;
      wait_clk(2);
      spi_cs_n = 1'b0;
      wait_clk(4);
      send_byte(op);
      for (int k = 0; k < nb; k++)
         send_byte((k < 3) ? ad[23 - 8*k -: 8] : (8'hA5 ^ 8'(k)));
      for (int e = 0; e < ext; e++) send_bit(1'b1);
      wait_clk(4);
      spi_cs_n = 1'b1;
      wait_clk(12);
      busy_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int e0, r0;
      wait_clk(5);
      // R10 reset state
      check(wel_o == 1'b0, "R10 latch in reset", int'(wel_o), 0);
      check(!exec_valid_o && !rd_start_o, "R10 strobes in reset",
            int'({exec_valid_o, rd_start_o}), 0);
      rst_n = 1'b1;
      wait_clk(5);

      for (int v = 0; v < NV; v++) begin
         e0 = exec_seen;
         r0 = rd_seen;
         frame(VEC[v].op, VEC[v].ad, int'(VEC[v].nb), int'(VEC[v].ext), VEC[v].bz);
         check((exec_seen - e0) == int'(VEC[v].xe),
               $sformatf("R%0d vec %0d execute count", VEC[v].req, v),
               exec_seen - e0, int'(VEC[v].xe));
         if (VEC[v].xe) begin
            check(last_cmd == VEC[v].xcmd, $sformatf("R%0d vec %0d command", VEC[v].req, v),
                  int'(last_cmd), int'(VEC[v].xcmd));
            // R1 address assembled first byte high
            check(last_addr == ((VEC[v].xcmd >= 4'd3 && VEC[v].xcmd <= 4'd6) ? VEC[v].ad : 24'd0),
                  $sformatf("R1 vec %0d execute address", v), int'(last_addr), int'(VEC[v].ad));
            check(last_cnt == VEC[v].xcnt, $sformatf("R%0d vec %0d byte count", VEC[v].req, v),
                  int'(last_cnt), int'(VEC[v].xcnt));
         end
         check(wel_o == VEC[v].xwel, $sformatf("R%0d vec %0d latch", VEC[v].req, v),
               int'(wel_o), int'(VEC[v].xwel));
         check((rd_seen - r0) == int'(VEC[v].xrd),
               $sformatf("R%0d vec %0d read start count", VEC[v].req, v),
               rd_seen - r0, int'(VEC[v].xrd));
         if (VEC[v].xrd) begin
            check(last_rcmd == VEC[v].xrcmd, $sformatf("R%0d vec %0d read command", VEC[v].req, v),
                  int'(last_rcmd), int'(VEC[v].xrcmd));
            check(last_raddr == VEC[v].ad, $sformatf("R1 vec %0d read address", v),
                  int'(last_raddr), int'(VEC[v].ad));
         end
      end

      // R13 partial window of five bits, then a clean write enable
      spi_cs_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      wait_clk(4);
      spi_cs_n = 1'b1;
      wait_clk(12);
      check(wel_o == 1'b0, "R13 partial window ignored", int'(wel_o), 0);
      e0 = exec_seen;
      frame(8'h06, 24'd0, 0, 0, 1'b0);
      check((exec_seen - e0) == 1 && wel_o, "R13 next window framed from zero",
            int'(wel_o), 1);

      // R11 every strobe was a single cycle
      check(long_pulse == 0, "R11 strobe width", long_pulse, 0);

      // R10 reset clears the latch
      wait_clk(2);
      rst_n = 1'b0;
      wait_clk(3);
      check(wel_o == 1'b0, "R10 latch after reset", int'(wel_o), 0);
      rst_n = 1'b1;
      wait_clk(3);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule